// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block stores up to `WORDS` entries of `WIDTH` bits and looks them up by content instead of by address. A search presents an argument word and a key mask. Every occupied entry is compared with the argument at the same time. Only the bit columns where the key holds a 1 take part in the comparison. The per-entry results are captured in a match vector with one bit per entry. That vector is then walked from entry 0 upward, and the block presents one matching entry per clock on a read port that carries the stored word, its index and a final-item flag. When no entry matches, the block gives a one-cycle no-match pulse instead.

Entries are added without an address. The block places the word in the lowest-numbered free entry and raises a full flag once every entry is in use. A write that arrives while the block is full is dropped. A clear request with an entry index frees that entry for later writes. While a scan is in progress, the block is busy and ignores new searches, writes and clears. This keeps the captured match vector consistent with the stored words.

Top module: `cam_masked`

## Requirements
- R1: After reset no entry is occupied, and `full`, `busy`, `rdValid`, `rdLast` and `noMatch` are all 0.
- R2: An occupied entry matches when, for every bit position i where `srchKey[i]` is 1, the stored bit i equals `srchArg[i]`. Positions where the key is 0 are ignored. A key of all ones requires an exact match.
- R3: An unoccupied entry never matches, whatever its former contents and whatever the key, including a key of all zeros.
- R4: A search is accepted on a rising edge where `srchValid` is 1 and `busy` is 0. The match vector is taken from the contents as they stood before any write or clear accepted on that same edge.
- R5: From the cycle after an accepted search, `busy` is 1. On each clock, one matching entry appears with `rdValid` = 1, its stored word on `rdData` and its index on `rdIndex`. The entries appear in strictly ascending index order.
- R6: `rdLast` is 1 together with the final matching entry only. In the cycle after that entry, `busy` and `rdValid` are 0.
- R7: If no entry matches, the cycle after the search shows `noMatch` = 1 with `rdValid` = 0 for exactly one cycle. `busy` is 0 again after that cycle.
- R8: A write accepted while not full (`wrValid` = 1, `busy` = 0, `full` = 0) stores `wrData` in the lowest-indexed unoccupied entry and marks that entry occupied.
- R9: `full` is 1 exactly when all entries are occupied. A write while `full` is 1 changes no entry.
- R10: A clear accepted with `busy` = 0 marks entry `clrIdx` unoccupied. That entry stops matching, and a later write reuses it when it is the lowest free entry.
- R11: While `busy` is 1, `srchValid`, `wrValid` and `clrValid` have no effect. The scan in progress continues unchanged, and the stored entries stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| srchValid | input | 1 | Start a search |
| srchArg | input | WIDTH | Argument word compared against the entries |
| srchKey | input | WIDTH | Per-bit compare enable; 1 = column takes part |
| wrValid | input | 1 | Store `wrData` in a free entry |
| wrData | input | WIDTH | Word to store |
| clrValid | input | 1 | Free the entry named by `clrIdx` |
| clrIdx | input | $clog2(WORDS) | Entry to free |
| busy | output | 1 | Scan in progress; other requests ignored |
| full | output | 1 | Every entry occupied |
| rdValid | output | 1 | A matching entry is presented this cycle |
| rdData | output | WIDTH | Stored word of the presented entry |
| rdIndex | output | $clog2(WORDS) | Index of the presented entry |
| rdLast | output | 1 | Presented entry is the final match |
| noMatch | output | 1 | Search found no matching entry |

## Verification
The assertions assume that `clrIdx` names an existing entry (below `WORDS`) whenever `clrValid` is high. They also assume the inputs are stable around the rising edge. The bench drives every input on the falling edge and only picks clear indices inside the array. No assertion depends on the requester waiting for `busy` to fall. The bench deliberately raises search, write and clear requests during a scan, so the ignore path for R11 is exercised rather than avoided.

// File: rtl/cam_pkg.sv
package cam_pkg;

  // Strobes issued by the sequencer to the storage datapath.
  typedef struct packed {
    logic loadMatch;  // capture compare vector into match register
    logic popMatch;   // retire the lowest set match bit
    logic doWrite;    // store write word into lowest free entry
    logic doClear;    // release the entry named by the clear index
  } camStrobe_t;

endpackage

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  camStrobe_t       ctl,
  input  logic [WIDTH-1:0] srchArg,
  input  logic [WIDTH-1:0] srchKey,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] clrIdx,
  output logic             matchAny,
  output logic             matchLast,
  output logic             full,
  output logic [WIDTH-1:0] rdData,
  output logic [IDX_W-1:0] rdIndex
);

  logic [WIDTH-1:0] store [WORDS];
  logic [WORDS-1:0] occ;
  logic [WORDS-1:0] occNext;
  logic [WORDS-1:0] hitVec;
  logic [WORDS-1:0] matchReg;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] scanIdx;

  // Parallel masked compare, one comparator per entry.
  for (genvar g = 0; g < WORDS; g++) begin : gCmp
    assign hitVec[g] = occ[g] && (((store[g] ^ srchArg) & srchKey) == '0);
  end

  // Lowest unoccupied entry.
  always_comb begin
    freeIdx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (!occ[i]) freeIdx = IDX_W'(i);
    end
  end

  // Lowest pending match.
  always_comb begin
    scanIdx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (matchReg[i]) scanIdx = IDX_W'(i);
    end
  end

  assign full      = &occ;
  assign matchAny  = |matchReg;
  assign matchLast = matchAny && ((matchReg & (matchReg - 1'b1)) == '0);
  assign rdData    = store[scanIdx];
  assign rdIndex   = scanIdx;

  always_comb begin
    occNext = occ;
    if (ctl.doClear) occNext[clrIdx] = 1'b0;
    if (ctl.doWrite) occNext[freeIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ      <= '0;
      matchReg <= '0;
    end else begin
      occ <= occNext;
      if (ctl.loadMatch) matchReg <= hitVec;
      else if (ctl.popMatch) matchReg[scanIdx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) store[i] <= '0;
    end else if (ctl.doWrite) begin
      store[freeIdx] <= wrData;
    end
  end

  AST_WRITE_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doWrite |-> !full); // R9
  AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doWrite |=> occ[$past(freeIdx)]); // R8
  AST_CLEAR_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.doClear && !ctl.doWrite) |=> !occ[$past(clrIdx)]); // R10
  AST_MATCH_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadMatch |=> ((matchReg & ~$past(occ)) == '0)); // R3
  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.popMatch |=> ($countones(matchReg) == $countones($past(matchReg)) - 1)); // R5
  AST_NO_LOAD_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.loadMatch && ctl.popMatch)); // R4

endmodule

// File: rtl/cam_control.sv
module cam_control
  import cam_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srchValid,
  input  logic       wrValid,
  input  logic       clrValid,
  input  logic       matchAny,
  input  logic       matchLast,
  input  logic       full,
  output camStrobe_t ctl,
  output logic       busy,
  output logic       rdValid,
  output logic       rdLast,
  output logic       noMatch
);

  typedef enum logic {ST_IDLE, ST_SCAN} camState_t;

  camState_t state;
  camState_t stateNext;

  always_comb begin
    stateNext     = state;
    ctl           = '0;
    rdValid       = 1'b0;
    rdLast        = 1'b0;
    noMatch       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.doWrite = wrValid && !full;
        ctl.doClear = clrValid;
        if (srchValid) begin
          ctl.loadMatch = 1'b1;
          stateNext     = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (matchAny) begin
          rdValid      = 1'b1;
          rdLast       = matchLast;
          ctl.popMatch = 1'b1;
          if (matchLast) stateNext = ST_IDLE;
        end else begin
          noMatch   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state == ST_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && rdLast) |=> (!busy && !rdValid)); // R6
  AST_NOMATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    noMatch |-> !rdValid); // R7
  AST_NOMATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    noMatch |=> !noMatch); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!ctl.doWrite && !ctl.doClear && !ctl.loadMatch)); // R11
  AST_SEARCH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (srchValid && !busy) |=> busy); // R4

endmodule

// File: rtl/cam_masked.sv
module cam_masked
  import cam_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srchValid,
  input  logic [WIDTH-1:0] srchArg,
  input  logic [WIDTH-1:0] srchKey,
  input  logic             wrValid,
  input  logic [WIDTH-1:0] wrData,
  input  logic             clrValid,
  input  logic [IDX_W-1:0] clrIdx,
  output logic             busy,
  output logic             full,
  output logic             rdValid,
  output logic [WIDTH-1:0] rdData,
  output logic [IDX_W-1:0] rdIndex,
  output logic             rdLast,
  output logic             noMatch
);

  camStrobe_t ctl;
  logic       matchAny;
  logic       matchLast;

  cam_control u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .srchValid (srchValid),
    .wrValid   (wrValid),
    .clrValid  (clrValid),
    .matchAny  (matchAny),
    .matchLast (matchLast),
    .full      (full),
    .ctl       (ctl),
    .busy      (busy),
    .rdValid   (rdValid),
    .rdLast    (rdLast),
    .noMatch   (noMatch)
  );

  cam_datapath #(
    .WORDS (WORDS),
    .WIDTH (WIDTH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .srchArg   (srchArg),
    .srchKey   (srchKey),
    .wrData    (wrData),
    .clrIdx    (clrIdx),
    .matchAny  (matchAny),
    .matchLast (matchLast),
    .full      (full),
    .rdData    (rdData),
    .rdIndex   (rdIndex)
  );

  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdValid && noMatch)); // R7
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rdLast |-> rdValid); // R6

endmodule

// File: tb/tb_cam_masked.sv
`timescale 1ns/100ps
module tb_cam_masked;

  localparam int WORDS = 8;
  localparam int WIDTH = 16;
  localparam int IDX_W = $clog2(WORDS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             srchValid = 1'b0;
  logic [WIDTH-1:0] srchArg = '0;
  logic [WIDTH-1:0] srchKey = '0;
  logic             wrValid = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             clrValid = 1'b0;
  logic [IDX_W-1:0] clrIdx = '0;
  logic             busy, full, rdValid, rdLast, noMatch;
  logic [WIDTH-1:0] rdData;
  logic [IDX_W-1:0] rdIndex;

  int checks = 0;
  int errors = 0;

  logic [WIDTH-1:0] refMem [WORDS];
  logic             refOcc [WORDS];

  always #2.5 clk = ~clk;

  cam_masked #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n),
    .srchValid(srchValid), .srchArg(srchArg), .srchKey(srchKey),
    .wrValid(wrValid), .wrData(wrData),
    .clrValid(clrValid), .clrIdx(clrIdx),
    .busy(busy), .full(full), .rdValid(rdValid), .rdData(rdData),
    .rdIndex(rdIndex), .rdLast(rdLast), .noMatch(noMatch)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit refFull();
    for (int i = 0; i < WORDS; i++) if (!refOcc[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic doWrite(input logic [WIDTH-1:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    if (!refFull()) begin
      for (int i = 0; i < WORDS; i++) begin
        if (!refOcc[i]) begin
          refOcc[i] = 1'b1;
          refMem[i] = d;
          break;
        end
      end
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doClear(input int idx);
    @(negedge clk);
    clrValid = 1'b1;
    clrIdx   = IDX_W'(idx);
    refOcc[idx] = 1'b0;
    @(negedge clk);
    clrValid = 1'b0;
  endtask

  // Search and compare the whole result stream against the model.
  task automatic runSearch(input logic [WIDTH-1:0] arg, input logic [WIDTH-1:0] key,
                           input bit inject, input string req);
    int expIdx [WORDS];
    int expCnt = 0;
    int got = 0;
    bit done = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      if (refOcc[i] && (((refMem[i] ^ arg) & key) == '0)) begin
        expIdx[expCnt] = i;
        expCnt++;
      end
    end
    @(negedge clk);
    srchValid = 1'b1;
    srchArg   = arg;
    srchKey   = key;
    @(negedge clk);
    srchValid = 1'b0;
    for (int c = 0; c < WORDS + 2 && !done; c++) begin
      if (noMatch) begin
        done = 1'b1;
        chk(expCnt == 0, {req, " R7 noMatch"}, 1, expCnt == 0);
        chk(!rdValid, {req, " R7 rdValid low"}, rdValid, 0);
      end else if (rdValid) begin
        if (got < expCnt) begin
          chk(int'(rdIndex) == expIdx[got], {req, " R5 index"}, rdIndex, expIdx[got]);
          chk(rdData == refMem[expIdx[got]], {req, " R2 data"}, rdData, refMem[expIdx[got]]);
          chk(rdLast == (got == expCnt - 1), {req, " R6 last"}, rdLast, got == expCnt - 1);
        end
        chk(busy, {req, " R5 busy"}, busy, 1);
        got++;
        if (rdLast) done = 1'b1;
      end
      if (inject && c == 0) begin
        srchValid = 1'b1; srchArg = '0; srchKey = '0;
        wrValid = 1'b1; wrData = 16'hDEAD;
        clrValid = 1'b1; clrIdx = IDX_W'(expIdx[0]);
      end
      @(negedge clk);
      if (inject && c == 0) begin
        srchValid = 1'b0; wrValid = 1'b0; clrValid = 1'b0;
      end
    end
    chk(got == expCnt, {req, " R5 match count"}, got, expCnt);
    chk(!busy && !rdValid && !noMatch, {req, " R6 idle after scan"}, {busy, rdValid, noMatch}, 0);
  endtask

  task automatic testReset();
    chk(!full, "R1 full", full, 0);
    chk(!busy, "R1 busy", busy, 0);
    chk(!rdValid && !rdLast && !noMatch, "R1 outputs", {rdValid, rdLast, noMatch}, 0);
    runSearch(16'h0000, 16'h0000, 0, "R1 R3 empty");
  endtask

  task automatic testWriteExact();
    doWrite(16'h12A5);
    doWrite(16'h34A5);
    doWrite(16'h5677);
    runSearch(16'h34A5, 16'hFFFF, 0, "R8 R2 exact idx1");
    runSearch(16'h5677, 16'hFFFF, 0, "R8 R2 exact idx2");
    runSearch(16'h34A4, 16'hFFFF, 0, "R2 exact miss");
  endtask

  task automatic testMasked();
    runSearch(16'h00A5, 16'h00FF, 0, "R2 R5 R6 low byte");
    runSearch(16'h0007, 16'h000F, 0, "R2 nibble");
    runSearch(16'hFFFF, 16'h0000, 0, "R3 key zero");
  endtask

  task automatic testClearReuse();
    doClear(1);
    runSearch(16'h34A5, 16'hFFFF, 0, "R10 cleared miss");
    runSearch(16'h0000, 16'h0000, 0, "R3 after clear");
    doWrite(16'hBEEF);
    runSearch(16'hBEEF, 16'hFFFF, 0, "R10 R8 reuse idx1");
  endtask

  task automatic testFull();
    for (int i = 0; i < 5; i++) doWrite(16'h0A00 + 16'(i));
    chk(full, "R9 full set", full, 1);
    doWrite(16'hCAFE);
    runSearch(16'hCAFE, 16'hFFFF, 0, "R9 write when full dropped");
    runSearch(16'h0A00, 16'hFF00, 0, "R5 five in order");
    doClear(6);
    chk(!full, "R9 full drops", full, 0);
  endtask

  task automatic testBusyIgnore();
    // several matches so the scan lasts more than one cycle
    runSearch(16'h0A00, 16'hFF00, 1, "R11 inject during scan");
    runSearch(16'hDEAD, 16'hFFFF, 0, "R11 write ignored");
    runSearch(16'h0000, 16'h0000, 0, "R11 contents kept");
  endtask

  task automatic testSameCycle();
    // entry 6 is free; search for the word written on the same edge
    @(negedge clk);
    srchValid = 1'b1; srchArg = 16'h7777; srchKey = 16'hFFFF;
    wrValid = 1'b1; wrData = 16'h7777;
    @(negedge clk);
    srchValid = 1'b0; wrValid = 1'b0;
    chk(noMatch, "R4 snapshot before write", noMatch, 1);
    chk(!rdValid, "R4 no stale read", rdValid, 0);
    refOcc[6] = 1'b1; refMem[6] = 16'h7777;
    @(negedge clk);
    runSearch(16'h7777, 16'hFFFF, 0, "R4 R8 found later");
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      refMem[i] = '0;
      refOcc[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testWriteExact();
    testMasked();
    testClearReuse();
    testFull();
    testBusyIgnore();
    testSameCycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule